// File: doc/BRIEF.md
# Sum-Together Multiply-Accumulate Unit

This block is a signed multiply-accumulate unit for low-precision integer arithmetic of the kind used in quantized neural network inference. Each cycle it accepts two 16-bit operand words and a precision select. The operand words are read as one 16-bit lane, two 8-bit lanes or four 4-bit lanes. In the narrow settings every lane pair is multiplied at the same time, and the lane products are added into a single sum. That sum, or the single wide product, is then added to a running 40-bit accumulator. Each operation is therefore a short dot-product step, and its width doubles each time the precision is halved.

A register stage sits between the inputs and the accumulator update. The unit has no state machine in the usual sense. Each cycle the registered controls pick one of four accumulator actions: HOLD (no operation), ZERO (clear only), LOAD (clear together with an operation) and ADD (an operation alone). The accumulator takes that action on the next edge, and the output valid flag follows the registered valid.

Top module: `st_mac`

## Requirements
- R1: With `mode` = 2'b00, an accepted operation adds the signed product of the full 16-bit words `op_a` and `op_b` to the accumulator.
- R2: With `mode` = 2'b01, lane 0 is bits [7:0] and lane 1 is bits [15:8]. Lane i of `op_a` is multiplied only by lane i of `op_b`, and the sum of the two products is added to the accumulator.
- R3: With `mode` = 2'b10, lane i is bits [4i+3:4i] for i = 0..3. The sum of the four lane-i by lane-i products is added to the accumulator.
- R4: With `mode` = 2'b11 (reserved), the unit behaves exactly as with `mode` = 2'b00.
- R5: Every lane is a two's-complement value, sign-extended from its own top bit. Examples: 4'h8 is -8 and 8'h80 is -128.
- R6: An accepted operation without `acc_clr` adds its result to the previous accumulator value, wrapping modulo 2^40.
- R7: When `acc_clr` and `in_valid` are high in the same cycle, the accumulator is loaded with that operation's result alone.
- R8: When `acc_clr` is high without `in_valid`, the accumulator becomes zero and `out_valid` stays low.
- R9: The accumulator value and `out_valid` for an input sampled at rising edge k appear after rising edge k+1. `out_valid` is high in exactly the cycles that follow an accepted input in this way.
- R10: A cycle with neither `in_valid` nor `acc_clr` leaves the accumulator unchanged.
- R11: While `rst_n` is low, `acc_o` is zero and `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and mode are presented this cycle |
| acc_clr | input | 1 | Discard the accumulated value |
| mode | input | 2 | Precision select: 00 = 16-bit, 01 = 8-bit, 10 = 4-bit, 11 = 16-bit |
| op_a | input | 16 | Packed operand word A, lane 0 in the least significant bits |
| op_b | input | 16 | Packed operand word B, lane 0 in the least significant bits |
| acc_o | output | 40 | Signed accumulator |
| out_valid | output | 1 | Accumulator reflects an operation accepted two edges earlier |

## Verification
The hardest case to reach from the ports is an error in one narrow lane that the other lanes' products cancel or mask in the shared sum. Such an error could come from a lane pairing with the wrong partner or from sign extension taken from the wrong bit. To expose it, the stimulus takes each nibble lane in turn through all 256 value pairs, and each byte lane through all 256 values of A against sixteen spread values of B. Meanwhile the other lanes carry values that change with every step. A stream of mixed modes with sporadic clears, clear-only cycles and idle cycles then checks the accumulator against an arithmetic model on every cycle.

// File: rtl/st_mac_pkg.sv
package st_mac_pkg;

    typedef enum logic [1:0] {
        PM_W16 = 2'b00,
        PM_W8  = 2'b01,
        PM_W4  = 2'b10,
        PM_RSV = 2'b11
    } prec_e;

    typedef enum logic [1:0] {
        ACT_HOLD,
        ACT_ZERO,
        ACT_LOAD,
        ACT_ADD
    } acc_act_e;

    localparam int N_PREC = 3;

endpackage

// File: rtl/st_lane_dot.sv
module st_lane_dot #(
    parameter int OP_W   = 16,
    parameter int LANE_W = 8,
    parameter int SUM_W  = 34
) (
    input  logic [OP_W-1:0]         a_i,
    input  logic [OP_W-1:0]         b_i,
    output logic signed [SUM_W-1:0] sum_o
);
    localparam int LANES = OP_W / LANE_W;
    localparam int PW    = 2 * LANE_W;
    localparam int EXT   = SUM_W - PW;

    logic signed [SUM_W-1:0] prod_ext [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0]    a_l;
        logic [LANE_W-1:0]    b_l;
        logic signed [PW-1:0] a_x;
        logic signed [PW-1:0] b_x;
        logic signed [PW-1:0] p;

        assign a_l = a_i[g*LANE_W +: LANE_W];
        assign b_l = b_i[g*LANE_W +: LANE_W];
        // sign extension from the lane's own top bit
        assign a_x = {{LANE_W{a_l[LANE_W-1]}}, a_l};
        assign b_x = {{LANE_W{b_l[LANE_W-1]}}, b_l};
        assign p   = a_x * b_x;
        assign prod_ext[g] = {{EXT{p[PW-1]}}, p};
    end

    always_comb begin
        sum_o = '0;
        for (int i = 0; i < LANES; i++) begin
            sum_o = sum_o + prod_ext[i];
        end
    end

endmodule

// File: rtl/st_prod_sel.sv
module st_prod_sel
    import st_mac_pkg::*;
#(
    parameter int OP_W  = 16,
    parameter int SUM_W = 34
) (
    input  logic [1:0]              mode_i,
    input  logic [OP_W-1:0]         a_i,
    input  logic [OP_W-1:0]         b_i,
    output logic signed [SUM_W-1:0] prod_o
);
    logic signed [SUM_W-1:0] dot [N_PREC];

    // one dot-product datapath per precision: lane width OP_W >> k
    for (genvar k = 0; k < N_PREC; k++) begin : g_prec
        st_lane_dot #(
            .OP_W  (OP_W),
            .LANE_W(OP_W >> k),
            .SUM_W (SUM_W)
        ) u_dot (
            .a_i  (a_i),
            .b_i  (b_i),
            .sum_o(dot[k])
        );
    end

    always_comb begin
        unique case (prec_e'(mode_i))
            PM_W8:          prod_o = dot[1];
            PM_W4:          prod_o = dot[2];
            PM_W16, PM_RSV: prod_o = dot[0];
            default:        prod_o = dot[0];
        endcase
    end

endmodule

// File: rtl/st_acc.sv
module st_acc
    import st_mac_pkg::*;
#(
    parameter int SUM_W = 34,
    parameter int ACC_W = 40
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    vld_i,
    input  logic                    clr_i,
    input  logic signed [SUM_W-1:0] prod_i,
    output logic signed [ACC_W-1:0] acc_o,
    output logic                    vld_o
);
    localparam int EXT = ACC_W - SUM_W;

    logic                    vld_q;
    logic                    clr_q;
    logic signed [SUM_W-1:0] prod_q;
    logic signed [ACC_W-1:0] addend;
    acc_act_e                act;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            clr_q  <= 1'b0;
            prod_q <= '0;
        end else begin
            vld_q <= vld_i;
            clr_q <= clr_i;
            if (vld_i) begin
                prod_q <= prod_i;
            end
        end
    end

    assign addend = {{EXT{prod_q[SUM_W-1]}}, prod_q};

    always_comb begin
        unique case ({vld_q, clr_q})
            2'b00:   act = ACT_HOLD;
            2'b01:   act = ACT_ZERO;
            2'b11:   act = ACT_LOAD;
            2'b10:   act = ACT_ADD;
            default: act = ACT_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_o <= '0;
            vld_o <= 1'b0;
        end else begin
            vld_o <= vld_q;
            unique case (act)
                ACT_ZERO: acc_o <= '0;
                ACT_LOAD: acc_o <= addend;
                ACT_ADD:  acc_o <= acc_o + addend;
                ACT_HOLD: acc_o <= acc_o;
                default:  acc_o <= acc_o;
            endcase
        end
    end

endmodule

// File: rtl/st_mac.sv
module st_mac #(
    parameter int OP_W  = 16,
    parameter int ACC_W = 40
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    acc_clr,
    input  logic [1:0]              mode,
    input  logic [OP_W-1:0]         op_a,
    input  logic [OP_W-1:0]         op_b,
    output logic signed [ACC_W-1:0] acc_o,
    output logic                    out_valid
);
    localparam int SUM_W = 2 * OP_W + 2;

    logic signed [SUM_W-1:0] prod;

    st_prod_sel #(
        .OP_W (OP_W),
        .SUM_W(SUM_W)
    ) u_sel (
        .mode_i(mode),
        .a_i   (op_a),
        .b_i   (op_b),
        .prod_o(prod)
    );

    st_acc #(
        .SUM_W(SUM_W),
        .ACC_W(ACC_W)
    ) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .vld_i (in_valid),
        .clr_i (acc_clr),
        .prod_i(prod),
        .acc_o (acc_o),
        .vld_o (out_valid)
    );

endmodule

// File: rtl/st_mac_chk.sv
module st_mac_chk #(
    parameter int ACC_W = 40
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic                    acc_clr,
    input logic [1:0]              mode,
    input logic signed [ACC_W-1:0] acc_o,
    input logic                    out_valid
);
    localparam logic signed [ACC_W-1:0] W4_LO = ACC_W'(-224);
    localparam logic signed [ACC_W-1:0] W4_HI = ACC_W'(256);
    localparam logic signed [ACC_W-1:0] W8_LO = ACC_W'(-32512);
    localparam logic signed [ACC_W-1:0] W8_HI = ACC_W'(32768);

    p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);

    p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 !out_valid);

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!in_valid, 2) && $past(!acc_clr, 2)) |-> $stable(acc_o));

    p_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(acc_clr && !in_valid, 2) |-> (acc_o == '0));

    p_w4_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid && acc_clr && mode == 2'b10, 2)
            |-> (acc_o >= W4_LO && acc_o <= W4_HI));

    p_w8_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid && acc_clr && mode == 2'b01, 2)
            |-> (acc_o >= W8_LO && acc_o <= W8_HI));

endmodule

bind st_mac st_mac_chk #(.ACC_W(ACC_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .acc_clr  (acc_clr),
    .mode     (mode),
    .acc_o    (acc_o),
    .out_valid(out_valid)
);

// File: tb/sim_st_mac.sv
module sim_st_mac;
    localparam int CLK_PERIOD = 10;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic               acc_clr = 1'b0;
    logic [1:0]         mode = 2'b00;
    logic [15:0]        op_a = '0;
    logic [15:0]        op_b = '0;
    logic signed [39:0] acc_o;
    logic               out_valid;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 0;

    logic [39:0] model_acc = '0;
    logic [39:0] h1_acc = '0, h2_acc = '0;
    logic        h1_v = 1'b0, h2_v = 1'b0;
    string       h1_tag = "R11", h2_tag = "R11";
    logic [31:0] seed = 32'h1234_5678;

    always #(CLK_PERIOD/2) clk = ~clk;

    st_mac u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .acc_clr  (acc_clr),
        .mode     (mode),
        .op_a     (op_a),
        .op_b     (op_b),
        .acc_o    (acc_o),
        .out_valid(out_valid)
    );

    function automatic longint dot_ref(input logic [1:0] m, input logic [15:0] a,
                                       input logic [15:0] b);
        int     lw;
        longint s;
        lw = (m == 2'b01) ? 8 : (m == 2'b10) ? 4 : 16;
        s = 0;
        for (int i = 0; i < 16 / lw; i++) begin
            longint va, vb, half;
            half = longint'(1) << (lw - 1);
            va = (longint'(a) >> (i * lw)) & ((half << 1) - 1);
            vb = (longint'(b) >> (i * lw)) & ((half << 1) - 1);
            if (va >= half) va = va - 2 * half;
            if (vb >= half) vb = vb - 2 * half;
            s = s + va * vb;
        end
        return s;
    endfunction

    function automatic logic [31:0] lcg(input logic [31:0] s);
        return s * 32'd1103515245 + 32'd12345;
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // one cycle: check the result of the op driven two steps ago, then drive a new op
    task automatic step(input logic v, input logic c, input logic [1:0] m,
                        input logic [15:0] a, input logic [15:0] b, input string tag);
        longint d;
        @(negedge clk);
        check(acc_o === h2_acc, h2_tag, longint'(acc_o), longint'(h2_acc));
        check(out_valid === h2_v, "R9", longint'(out_valid), longint'(h2_v));
        h2_acc = h1_acc; h2_v = h1_v; h2_tag = h1_tag;
        d = dot_ref(m, a, b);
        if (v) model_acc = c ? 40'(d) : model_acc + 40'(d);
        else if (c) model_acc = '0;
        h1_acc = model_acc; h1_v = v; h1_tag = tag;
        in_valid = v; acc_clr = c; mode = m; op_a = a; op_b = b;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check(acc_o === '0, "R11", longint'(acc_o), 0);
        check(out_valid === 1'b0, "R11", longint'(out_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R5: sign-extension corners
        step(1, 1, 2'b10, 16'h8888, 16'h8888, "R5");
        step(1, 1, 2'b10, 16'h8888, 16'h7777, "R5");
        step(1, 1, 2'b01, 16'h8080, 16'h7F7F, "R5");
        step(1, 1, 2'b01, 16'h8080, 16'h8080, "R5");
        step(1, 1, 2'b00, 16'h8000, 16'h8000, "R5");
        step(1, 1, 2'b00, 16'h8000, 16'h7FFF, "R5");
        step(1, 1, 2'b10, 16'h00F0, 16'h000F, "R5");

        // R3: each nibble lane through all 256 pairs, other lanes moving
        for (int x = 0; x < 256; x++) begin
            for (int ln = 0; ln < 4; ln++) begin
                logic [15:0] a, b;
                logic [7:0]  xv;
                xv = 8'(x);
                a = 16'(x * 4321 + ln * 77);
                b = a ^ 16'hA5C3;
                a[ln*4 +: 4] = xv[3:0];
                b[ln*4 +: 4] = xv[7:4];
                step(1, 1, 2'b10, a, b, "R3");
            end
        end

        // R2: each byte lane, all A values against 16 spread B values
        for (int av = 0; av < 256; av++) begin
            for (int bj = 0; bj < 16; bj++) begin
                for (int ln = 0; ln < 2; ln++) begin
                    logic [15:0] a, b;
                    a = 16'(av * 2053 + bj * 91 + ln);
                    b = 16'(bj * 3001 + av * 7);
                    a[ln*8 +: 8] = 8'(av);
                    b[ln*8 +: 8] = 8'(bj * 17);
                    step(1, 1, 2'b01, a, b, "R2");
                end
            end
        end

        // R1: full-width products
        for (int i = 0; i < 3000; i++) begin
            seed = lcg(seed);
            step(1, 1, 2'b00, seed[31:16], seed[15:0] ^ 16'(i), "R1");
        end

        // R4: reserved mode behaves as full width
        for (int i = 0; i < 500; i++) begin
            seed = lcg(seed);
            step(1, 1, 2'b11, seed[15:0], seed[31:16], "R4");
        end

        // R6 / R7 / R8 / R10: deterministic sequence
        step(1, 1, 2'b01, 16'h7F7F, 16'h7F7F, "R7");
        step(1, 0, 2'b01, 16'h7F7F, 16'h7F7F, "R6");
        step(0, 0, 2'b00, 16'hFFFF, 16'hFFFF, "R10");
        step(0, 0, 2'b10, 16'h1234, 16'h5678, "R10");
        step(1, 0, 2'b00, 16'h8000, 16'h8000, "R6");
        step(0, 1, 2'b00, 16'h7FFF, 16'h7FFF, "R8");
        step(0, 0, 2'b00, 16'h0000, 16'h0000, "R10");
        step(1, 0, 2'b10, 16'h8888, 16'h8888, "R6");
        step(1, 1, 2'b00, 16'h0003, 16'hFFFE, "R7");

        // R6: long mixed stream with sporadic clears and idles
        for (int i = 0; i < 400; i++) begin
            logic v, c;
            string t;
            seed = lcg(seed);
            v = seed[20] | seed[21];
            c = (seed[27:22] == 6'd0);
            t = (v && c) ? "R7" : (c ? "R8" : (v ? "R6" : "R10"));
            step(v, c, seed[29:28], seed[15:0], seed[31:16] ^ seed[15:0], t);
        end

        // drain the last two operations
        step(0, 0, 2'b00, 16'h0, 16'h0, "R10");
        step(0, 0, 2'b00, 16'h0, 16'h0, "R10");
        step(0, 0, 2'b00, 16'h0, 16'h0, "R10");
        finish_run();
    end

endmodule